// File: doc/BRIEF.md
# Hart Local Interrupt Priority Selector

This block decides which local interrupt a hart takes next. Each interrupt line has a pending bit and an enable bit. A line counts as a candidate only when both bits are set. Each candidate is then routed to one of two handling levels by a per-line delegation bit. A clear delegation bit routes the line to the machine level, and a set bit routes it to the supervisor level. Each level has a global enable, and whether that enable applies depends on the hart's current privilege.

A level that sits above the current privilege always accepts its interrupts, whatever its own enable bit says. A level equal to the current privilege accepts them only when its enable bit is set. A level below the current privilege never accepts them. Of the candidates that pass this gate, the one with the smallest index wins. The valid flag and the cause number are registered once per clock, so the trap logic sees a stable request one cycle after the inputs it reflects.

Top module: `hart_irq_select`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first clock edge with reset inactive, `irq_valid_o` is 0 and `irq_cause_o` is 0.
- R2: Only a line whose `pend_i` bit and `en_i` bit are both 1 can be reported. A line with its `en_i` bit at 0 is never reported, even when it is pending.
- R3: The privilege input `priv_i` uses the codes U=0, S=1 and M=3. A line with its `deleg_i` bit at 0 is accepted when the privilege is U or S. At M it is accepted only when `m_ie_i` is 1.
- R4: A line with its `deleg_i` bit at 1 is always accepted at privilege U. At privilege S it is accepted only when `s_ie_i` is 1. At privilege M it is never accepted, whatever the value of `s_ie_i`.
- R5: The reserved privilege code 2 behaves exactly like S. Lines with `deleg_i` at 0 are accepted, and lines with `deleg_i` at 1 follow `s_ie_i`.
- R6: When several lines pass the gate, `irq_cause_o` gives the lowest bit index among them.
- R7: When no line passes the gate, `irq_valid_o` is 0 and `irq_cause_o` is 0.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge. A change at the inputs does not appear at the outputs before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | NUM_IRQ | Pending bit per interrupt line |
| en_i | input | NUM_IRQ | Enable bit per interrupt line |
| deleg_i | input | NUM_IRQ | 1 routes the line to the supervisor level, 0 to the machine level |
| m_ie_i | input | 1 | Machine-level global interrupt enable |
| s_ie_i | input | 1 | Supervisor-level global interrupt enable |
| priv_i | input | 2 | Current privilege: 0=U, 1=S, 2=reserved (acts as S), 3=M |
| irq_valid_o | output | 1 | A selected interrupt is present |
| irq_cause_o | output | $clog2(NUM_IRQ) | Index of the selected line, 0 when none |

## Verification
The assertions check the following on every cycle, against a registered copy of the previous inputs:
- the reported line was pending and enabled;
- nothing is reported at M without the machine enable, or on a supervisor-routed line;
- the reserved privilege code never reports a supervisor-routed line while the supervisor enable is clear;
- an empty candidate set gives an idle output with cause 0.

Some behaviours only the bench scenarios can show. These are the lowest-index choice among several surviving lines, that an interrupt for a higher level is taken regardless of that level's enable, and the exact one-cycle latency. The bench checks them against its reference function across random vectors and all four privilege codes.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

   localparam int PRIV_W = 2;

   typedef enum logic [PRIV_W-1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   // Selection network variants
   localparam int PICK_SCAN    = 0;
   localparam int PICK_ISOLATE = 1;

endpackage

// File: rtl/irq_level_gate.sv
// Turns the current privilege and the two global enables into one
// accept flag per handling level.
module irq_level_gate
   import irq_sel_pkg::*;
(
   input  logic [PRIV_W-1:0] priv_i,
   input  logic              m_ie_i,
   input  logic              s_ie_i,
   output logic              m_accept_o,
   output logic              s_accept_o
);

   priv_e priv;
   assign priv = priv_e'(priv_i);

   always_comb begin
      unique case (priv)
         PRIV_M: begin
            m_accept_o = m_ie_i;
            s_accept_o = 1'b0;
         end
         PRIV_S, PRIV_RSV: begin
            m_accept_o = 1'b1;
            s_accept_o = s_ie_i;
         end
         default: begin
            m_accept_o = 1'b1;
            s_accept_o = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/irq_lowest_pick.sv
// Finds the lowest set bit of a vector. The parameter picks the network:
// a scanning priority chain, or two's-complement isolation plus an OR encoder.
module irq_lowest_pick
   import irq_sel_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int STYLE = PICK_SCAN,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   assign found_o = |vec_i;

   generate
      if (STYLE == PICK_SCAN) begin : g_scan
         always_comb begin
            idx_o = '0;
            for (int i = WIDTH - 1; i >= 0; i--) begin
               if (vec_i[i]) idx_o = IDX_W'(i);
            end
         end
      end else begin : g_isolate
         logic [WIDTH-1:0] onehot;
         assign onehot = vec_i & (~vec_i + WIDTH'(1));
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < WIDTH; i++) begin
               if (onehot[i]) idx_o = idx_o | IDX_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/hart_irq_select.sv
module hart_irq_select
   import irq_sel_pkg::*;
#(
   parameter int NUM_IRQ    = 16,
   parameter int PICK_STYLE = PICK_SCAN,
   localparam int CAUSE_W   = $clog2(NUM_IRQ)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] pend_i,
   input  logic [NUM_IRQ-1:0] en_i,
   input  logic [NUM_IRQ-1:0] deleg_i,
   input  logic               m_ie_i,
   input  logic               s_ie_i,
   input  logic [1:0]         priv_i,
   output logic               irq_valid_o,
   output logic [CAUSE_W-1:0] irq_cause_o
);

   generate
      if (NUM_IRQ < 2 || NUM_IRQ > 64) begin : g_bad_width
         $error("hart_irq_select: NUM_IRQ must lie in 2..64");
      end
      if (PICK_STYLE != PICK_SCAN && PICK_STYLE != PICK_ISOLATE) begin : g_bad_style
         $error("hart_irq_select: unknown PICK_STYLE");
      end
   endgenerate

   logic               m_accept, s_accept;
   logic [NUM_IRQ-1:0] cand, route_ok, live;
   logic               found;
   logic [CAUSE_W-1:0] idx;

   irq_level_gate u_gate (
      .priv_i     (priv_i),
      .m_ie_i     (m_ie_i),
      .s_ie_i     (s_ie_i),
      .m_accept_o (m_accept),
      .s_accept_o (s_accept)
   );

   assign cand     = pend_i & en_i;
   assign route_ok = (~deleg_i & {NUM_IRQ{m_accept}}) | (deleg_i & {NUM_IRQ{s_accept}});
   assign live     = cand & route_ok;

   irq_lowest_pick #(
      .WIDTH (NUM_IRQ),
      .STYLE (PICK_STYLE)
   ) u_pick (
      .vec_i   (live),
      .found_o (found),
      .idx_o   (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid_o <= 1'b0;
         irq_cause_o <= '0;
      end else begin
         irq_valid_o <= found;
         irq_cause_o <= found ? idx : '0;
      end
   end

endmodule

// File: rtl/hart_irq_select_chk.sv
module hart_irq_select_chk #(
   parameter int NUM_IRQ = 16,
   localparam int CAUSE_W = $clog2(NUM_IRQ)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] pend_i,
   input logic [NUM_IRQ-1:0] en_i,
   input logic [NUM_IRQ-1:0] deleg_i,
   input logic               m_ie_i,
   input logic               s_ie_i,
   input logic [1:0]         priv_i,
   input logic               irq_valid_o,
   input logic [CAUSE_W-1:0] irq_cause_o
);

   // Inputs as sampled at the previous edge, to line up with the outputs
   logic [NUM_IRQ-1:0] cand_q, deleg_q;
   logic [1:0]         priv_q;
   logic               mie_q, sie_q;

   always_ff @(posedge clk) begin
      cand_q  <= pend_i & en_i;
      deleg_q <= deleg_i;
      priv_q  <= priv_i;
      mie_q   <= m_ie_i;
      sie_q   <= s_ie_i;
   end

   // R2: the reported line was a candidate
   a_r2_cause_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> cand_q[irq_cause_o]);

   // R3 and R4: at M, only machine-routed lines with the machine enable set
   a_r3_m_needs_mie: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid_o && priv_q == 2'd3) |-> (mie_q && !deleg_q[irq_cause_o]));

   // R4: at S, a supervisor-routed line needs the supervisor enable
   a_r4_s_needs_sie: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid_o && priv_q == 2'd1 && !sie_q) |-> !deleg_q[irq_cause_o]);

   // R5: the reserved code behaves like S
   a_r5_rsv_as_s: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid_o && priv_q == 2'd2 && !sie_q) |-> !deleg_q[irq_cause_o]);

   // R7: no candidate gives an idle output
   a_r7_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_q == '0) |-> !irq_valid_o);

   // R7: idle output carries cause 0
   a_r7_idle_zero_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid_o |-> (irq_cause_o == '0));

endmodule

bind hart_irq_select hart_irq_select_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pend_i      (pend_i),
   .en_i        (en_i),
   .deleg_i     (deleg_i),
   .m_ie_i      (m_ie_i),
   .s_ie_i      (s_ie_i),
   .priv_i      (priv_i),
   .irq_valid_o (irq_valid_o),
   .irq_cause_o (irq_cause_o)
);

// File: tb/hart_irq_select_bench.sv
`timescale 1ns/1ps
module hart_irq_select_bench;

   localparam int N  = 16;
   localparam int CW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pend = '0, en = '0, deleg = '0;
   logic          mie = 1'b0, sie = 1'b0;
   logic [1:0]    priv = 2'd0;
   logic          valid;
   logic [CW-1:0] cause;

   int n_checks = 0;
   int n_fail   = 0;
   logic          exp_v_q = 1'b0;
   logic [CW-1:0] exp_c_q = '0;

   always #10 clk = ~clk;

   hart_irq_select #(.NUM_IRQ(N)) u_hart_irq_select (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
      .m_ie_i(mie), .s_ie_i(sie), .priv_i(priv),
      .irq_valid_o(valid), .irq_cause_o(cause)
   );

   // Reference function built from the requirements
   function automatic logic [CW:0] ref_pick(
      input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d,
      input logic mi, input logic si, input logic [1:0] pv);
      logic m_ok, s_ok;
      logic [N-1:0] g;
      m_ok = (pv != 2'd3) || mi;
      s_ok = (pv == 2'd0) || ((pv == 2'd1 || pv == 2'd2) && si);
      g = p & e & ((~d & {N{m_ok}}) | (d & {N{s_ok}}));
      for (int i = 0; i < N; i++)
         if (g[i]) return {1'b1, CW'(i)};
      return '0;
   endfunction

   task automatic check(input string req, input logic ev, input logic [CW-1:0] ec);
      n_checks++;
      if (valid !== ev || cause !== ec) begin
         n_fail++;
         $display("FAIL %s: got valid=%0b cause=%0d, expected valid=%0b cause=%0d",
                  req, valid, cause, ev, ec);
      end
   endtask

   // Called just after a falling edge: drive, confirm no early change,
   // then check at the next falling edge.
   task automatic apply(input string req, input logic [N-1:0] p, input logic [N-1:0] e,
                        input logic [N-1:0] d, input logic mi, input logic si,
                        input logic [1:0] pv);
      logic [CW:0] r;
      pend = p; en = e; deleg = d; mie = mi; sie = si; priv = pv;
      r = ref_pick(p, e, d, mi, si, pv);
      #1;
      check("R8", exp_v_q, exp_c_q);
      @(negedge clk);
      check(req, r[CW], r[CW-1:0]);
      exp_v_q = r[CW];
      exp_c_q = r[CW-1:0];
   endtask

   initial begin
      #4000000;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] seed;
      seed = $urandom(32'h5eed_1234);
      pend = '1; en = '1;
      repeat (3) @(negedge clk);
      check("R1", 1'b0, '0);
      pend = '0; en = '0;
      @(negedge clk);
      rst_n = 1'b1;
      #1 check("R1", 1'b0, '0);
      @(negedge clk);

      // directed corners
      apply("R7", '0, '1, '0, 1, 1, 2'd3);
      apply("R2", 16'h00F0, 16'h00E0, '0, 1, 1, 2'd0);          // bit 4 masked, 5 wins
      apply("R6", 16'h8001, 16'hFFFF, '0, 1, 1, 2'd0);          // lowest: 0
      apply("R6", 16'h8000, 16'hFFFF, '0, 1, 1, 2'd1);          // top line alone
      apply("R3", 16'h0008, 16'hFFFF, '0, 0, 0, 2'd3);          // M, mie clear: none
      apply("R3", 16'h0008, 16'hFFFF, '0, 1, 0, 2'd3);          // M, mie set: 3
      apply("R3", 16'h0008, 16'hFFFF, '0, 0, 0, 2'd1);          // higher level ignores mie
      apply("R4", 16'h0004, 16'hFFFF, 16'h0004, 1, 1, 2'd3);    // S-routed at M: never
      apply("R4", 16'h0004, 16'hFFFF, 16'h0004, 0, 0, 2'd0);    // at U: always
      apply("R4", 16'h0004, 16'hFFFF, 16'h0004, 0, 0, 2'd1);    // at S, sie clear
      apply("R4", 16'h0004, 16'hFFFF, 16'h0004, 0, 1, 2'd1);    // at S, sie set
      apply("R5", 16'h0006, 16'hFFFF, 16'h0002, 0, 0, 2'd2);    // rsv: 1 blocked, 2 taken
      apply("R5", 16'h0006, 16'hFFFF, 16'h0002, 0, 1, 2'd2);    // rsv, sie set: 1
      apply("R6", 16'h0300, 16'hFFFF, 16'h0100, 1, 0, 2'd1);    // low line blocked, 9 wins
      apply("R7", 16'h0300, 16'h0000, '0, 1, 1, 2'd0);

      for (int k = 0; k < 3000; k++) begin
         logic [N-1:0] p, e, d;
         p = N'($urandom);
         e = N'($urandom) | N'($urandom);
         d = N'($urandom);
         if (k % 7 == 0) p = p & N'($urandom) & N'($urandom);
         apply("R6", p, e, d, 1'($urandom), 1'($urandom), 2'($urandom));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule